// File: doc/BRIEF.md
# Trap Entry Decision Unit

This block sits between the interrupt controller, the exception sources and the privileged register file of a core that runs in machine (M), supervisor (S) and user (U) modes. Each cycle it looks at the interrupts that are both pending and individually enabled, at a synchronous exception request, and at the current privilege and status. From these it decides whether a trap is taken and which mode handles it. It then works out the redirect PC, the new privilege, the new status word, the cause value and which exception-PC register is written.

A breakpoint exception can instead send the core into debug mode. This happens when the per-privilege breakpoint enable for the current mode is set. While the core is already in debug mode, any exception only redirects the PC to one of two fixed debug vectors.

All results are registered. They appear one clock after the inputs that caused them. The register file commits them when `trap_o` is high.

Top module: `trap_entry`

## Requirements
- R1: After reset, `trap_o`, all write enables and `dbg_enter_o` are 0, and `priv_o` is M (3). Privilege codes are U=0, S=1, M=3.
- R2: An interrupt whose `mideleg_i` bit is clear is enabled when the privilege is below M, or when it is M and MIE (mstatus bit 3) is set.
- R3: Delegated interrupts are considered only when no non-delegated interrupt is enabled. They are enabled when the privilege is U, or when it is S and SIE (mstatus bit 1) is set.
- R4: Among the enabled interrupts, the lowest-numbered bit wins. `cause_o` carries that number with bit XLEN-1 set.
- R5: A trap is handled in S-mode only when the privilege is U or S, the cause number is below XLEN, and the cause's bit in `medeleg_i` is set (or in `mideleg_i` for interrupts). Otherwise it is handled in M-mode.
- R6: On S-mode entry, the PC becomes `stvec_i` and privilege becomes S. In the status word, SPIE (bit 5) takes the old SIE, SPP (bit 8) takes bit 0 of the old privilege, and SIE is cleared. `sepc_we_o` is raised.
- R7: On M-mode entry, the PC is `mtvec_i` with bit 0 cleared. When `mtvec_i` bit 0 is set and the trap is an interrupt, 4 times the cause number is added.
- R8: On M-mode entry, privilege becomes M. MPIE (bit 7) takes the old MIE, MPP (bits 12:11) takes the old privilege, and MIE is cleared. `mepc_we_o` is raised.
- R9: When an interrupt is taken, an exception valid in the same cycle is dropped.
- R10: A breakpoint (cause 3) with `ebreak_en_i[priv_i]` set raises `dbg_enter_o`. The PC goes to the debug entry address and privilege becomes M. `dbg_prv_o` holds the old privilege. No epc enable is raised and the status word is unchanged.
- R11: In debug mode, a breakpoint redirects to the debug entry address and any other exception redirects to the debug trap vector. Privilege, status and all enables are left untouched, and interrupts are not taken.
- R12: `saved_pc_o` holds `pc_i` of the trapping cycle, and all outputs follow their inputs by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pend_i | input | XLEN | Interrupts pending and individually enabled |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | XLEN | Exception cause number |
| pc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege |
| mstatus_i | input | XLEN | Current status word |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| mtvec_i | input | XLEN | M-mode trap vector, bit 0 selects vectored |
| stvec_i | input | XLEN | S-mode trap vector |
| dbg_mode_i | input | 1 | Core is in debug mode |
| ebreak_en_i | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| trap_o | output | 1 | Redirect taken |
| trap_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Privilege after the event |
| mstatus_o | output | XLEN | Status word after the event |
| cause_o | output | XLEN | Cause value to record |
| mepc_we_o | output | 1 | Write M exception PC and cause |
| sepc_we_o | output | 1 | Write S exception PC and cause |
| saved_pc_o | output | XLEN | PC to save |
| dbg_enter_o | output | 1 | Enter debug mode (software breakpoint) |
| dbg_prv_o | output | 2 | Privilege to save on debug entry |

## Verification
The checker watches, on every cycle, the invariants that tie outputs together. It checks that mode entries set the right privilege and clear the right enable bit, that MPIE copies the prior MIE, that at most one write target is raised, that debug-mode redirects leave state untouched, and that an interrupt cause only follows a cycle with pending interrupts. Other behaviours need chosen stimulus, so only the bench scenarios show them. These are which interrupt wins a tie or loses to a lower delegated one, the vectored offset, the delegation limits by privilege and cause range, breakpoint routing against the enables, and interrupts beating a simultaneous exception.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;  // two bits, 12:11

  localparam int BKPT_CAUSE = 3;
endpackage

// File: rtl/irq_select.sv
module irq_select
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic            valid_o,
  output logic [IW-1:0]   idx_o
);
  logic            m_en, s_en;
  logic [XLEN-1:0] m_set, s_set, sel;

  always_comb begin
    m_en  = (priv_i != PRV_M) || mie_i;
    s_en  = (priv_i == PRV_U) || ((priv_i == PRV_S) && sie_i);
    m_set = pend_i & ~mideleg_i & {XLEN{m_en}};
    s_set = pend_i & mideleg_i & {XLEN{s_en}};
    // delegated set only when nothing stays in M
    sel   = (m_set != '0) ? m_set : s_set;
    valid_o = (sel != '0);
    idx_o = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (sel[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 32'h0000_0800,
  parameter logic [XLEN-1:0] DBG_TVEC  = 32'h0000_0808,
  localparam int IW = $clog2(XLEN)
) (
  input  logic            irq_valid_i,
  input  logic [IW-1:0]   irq_idx_i,
  input  logic            exc_valid_i,
  input  logic [XLEN-1:0] exc_cause_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] mstatus_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic            dbg_mode_i,
  input  logic [3:0]      ebreak_en_i,
  output logic            take_o,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] cause_o,
  output logic            mwe_o,
  output logic            swe_o,
  output logic            dbg_o
);
  localparam logic [XLEN-1:0] XLEN_V = XLEN;

  logic            irq_take, exc_take, to_s;
  logic [XLEN-1:0] num, deleg, vec_off;

  always_comb begin
    irq_take = irq_valid_i && !dbg_mode_i;
    exc_take = exc_valid_i && !irq_take;
    num      = irq_take ? XLEN'(irq_idx_i) : exc_cause_i;
    deleg    = irq_take ? mideleg_i : medeleg_i;
    to_s     = (priv_i == PRV_U || priv_i == PRV_S) && (num < XLEN_V)
               && deleg[num[IW-1:0]];
    vec_off  = (mtvec_i[0] && irq_take) ? (XLEN'(irq_idx_i) << 2) : '0;

    take_o    = 1'b0;
    pc_o      = '0;
    priv_o    = priv_i;
    mstatus_o = mstatus_i;
    cause_o   = '0;
    mwe_o     = 1'b0;
    swe_o     = 1'b0;
    dbg_o     = 1'b0;

    if (dbg_mode_i && exc_valid_i) begin
      take_o = 1'b1;
      pc_o   = (exc_cause_i == XLEN'(BKPT_CAUSE)) ? DBG_ENTRY : DBG_TVEC;
    end else if (exc_take && exc_cause_i == XLEN'(BKPT_CAUSE) && ebreak_en_i[priv_i]) begin
      take_o = 1'b1;
      pc_o   = DBG_ENTRY;
      priv_o = PRV_M;
      dbg_o  = 1'b1;
    end else if (irq_take || exc_take) begin
      take_o  = 1'b1;
      cause_o = irq_take ? {1'b1, {(XLEN-1-IW){1'b0}}, irq_idx_i} : exc_cause_i;
      if (to_s) begin
        pc_o   = stvec_i;
        priv_o = PRV_S;
        swe_o  = 1'b1;
        mstatus_o[ST_SPIE] = mstatus_i[ST_SIE];
        mstatus_o[ST_SPP]  = priv_i[0];
        mstatus_o[ST_SIE]  = 1'b0;
      end else begin
        pc_o   = {mtvec_i[XLEN-1:1], 1'b0} + vec_off;
        priv_o = PRV_M;
        mwe_o  = 1'b1;
        mstatus_o[ST_MPIE]          = mstatus_i[ST_MIE];
        mstatus_o[ST_MPP+1:ST_MPP]  = priv_i;
        mstatus_o[ST_MIE]           = 1'b0;
      end
    end
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 32'h0000_0800,
  parameter logic [XLEN-1:0] DBG_TVEC  = 32'h0000_0808
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] irq_pend_i,
  input  logic            exc_valid_i,
  input  logic [XLEN-1:0] exc_cause_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] mstatus_i,
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic            dbg_mode_i,
  input  logic [3:0]      ebreak_en_i,
  output logic            trap_o,
  output logic [XLEN-1:0] trap_pc_o,
  output logic [1:0]      priv_o,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] cause_o,
  output logic            mepc_we_o,
  output logic            sepc_we_o,
  output logic [XLEN-1:0] saved_pc_o,
  output logic            dbg_enter_o,
  output logic [1:0]      dbg_prv_o
);
  localparam int IW = $clog2(XLEN);

  logic            irq_valid;
  logic [IW-1:0]   irq_idx;
  logic            take_d, mwe_d, swe_d, dbg_d;
  logic [XLEN-1:0] pc_d, mst_d, cause_d;
  logic [1:0]      priv_d;

  irq_select #(.XLEN(XLEN)) u_irq (
    .pend_i    (irq_pend_i),
    .mideleg_i (mideleg_i),
    .priv_i    (priv_i),
    .mie_i     (mstatus_i[ST_MIE]),
    .sie_i     (mstatus_i[ST_SIE]),
    .valid_o   (irq_valid),
    .idx_o     (irq_idx)
  );

  trap_route #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY), .DBG_TVEC(DBG_TVEC)) u_route (
    .irq_valid_i (irq_valid),
    .irq_idx_i   (irq_idx),
    .exc_valid_i (exc_valid_i),
    .exc_cause_i (exc_cause_i),
    .priv_i      (priv_i),
    .mstatus_i   (mstatus_i),
    .medeleg_i   (medeleg_i),
    .mideleg_i   (mideleg_i),
    .mtvec_i     (mtvec_i),
    .stvec_i     (stvec_i),
    .dbg_mode_i  (dbg_mode_i),
    .ebreak_en_i (ebreak_en_i),
    .take_o      (take_d),
    .pc_o        (pc_d),
    .priv_o      (priv_d),
    .mstatus_o   (mst_d),
    .cause_o     (cause_d),
    .mwe_o       (mwe_d),
    .swe_o       (swe_d),
    .dbg_o       (dbg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o      <= 1'b0;
      trap_pc_o   <= '0;
      priv_o      <= PRV_M;
      mstatus_o   <= '0;
      cause_o     <= '0;
      mepc_we_o   <= 1'b0;
      sepc_we_o   <= 1'b0;
      saved_pc_o  <= '0;
      dbg_enter_o <= 1'b0;
      dbg_prv_o   <= PRV_U;
    end else begin
      trap_o      <= take_d;
      trap_pc_o   <= pc_d;
      priv_o      <= priv_d;
      mstatus_o   <= mst_d;
      cause_o     <= cause_d;
      mepc_we_o   <= mwe_d;
      sepc_we_o   <= swe_d;
      saved_pc_o  <= pc_i;
      dbg_enter_o <= dbg_d;
      dbg_prv_o   <= priv_i;
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] DBG_ENTRY = 32'h0000_0800
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] irq_pend_i,
  input logic [1:0]      priv_i,
  input logic [XLEN-1:0] mstatus_i,
  input logic            dbg_mode_i,
  input logic            trap_o,
  input logic [XLEN-1:0] trap_pc_o,
  input logic [1:0]      priv_o,
  input logic [XLEN-1:0] mstatus_o,
  input logic [XLEN-1:0] cause_o,
  input logic            mepc_we_o,
  input logic            sepc_we_o,
  input logic            dbg_enter_o
);
  // R6
  s_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sepc_we_o |-> trap_o && priv_o == 2'd1 && !mstatus_o[1]);

  // R8
  m_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mepc_we_o |-> trap_o && priv_o == 2'd3 && !mstatus_o[3]
                  && mstatus_o[7] == $past(mstatus_i[3]));

  // R10
  dbg_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_enter_o |-> trap_o && priv_o == 2'd3 && trap_pc_o == DBG_ENTRY);

  // R10
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mepc_we_o, sepc_we_o, dbg_enter_o}));

  // R11
  dbg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && $past(dbg_mode_i)) |->
      !mepc_we_o && !sepc_we_o && !dbg_enter_o && priv_o == $past(priv_i));

  // R4
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mepc_we_o || sepc_we_o) && cause_o[XLEN-1]) |-> $past(irq_pend_i) != '0);

  // R12
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> !mepc_we_o && !sepc_we_o && !dbg_enter_o);
endmodule

bind trap_entry trap_entry_chk #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_pend_i  (irq_pend_i),
  .priv_i      (priv_i),
  .mstatus_i   (mstatus_i),
  .dbg_mode_i  (dbg_mode_i),
  .trap_o      (trap_o),
  .trap_pc_o   (trap_pc_o),
  .priv_o      (priv_o),
  .mstatus_o   (mstatus_o),
  .cause_o     (cause_o),
  .mepc_we_o   (mepc_we_o),
  .sepc_we_o   (sepc_we_o),
  .dbg_enter_o (dbg_enter_o)
);

// File: tb/trap_entry_bench.sv
module trap_entry_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] DENT = 32'h0000_0800;
  localparam logic [31:0] DTVC = 32'h0000_0808;
  localparam logic [31:0] STV  = 32'h0000_0200;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] irq_pend_i, exc_cause_i, pc_i, mstatus_i, medeleg_i, mideleg_i, mtvec_i, stvec_i;
  logic        exc_valid_i, dbg_mode_i;
  logic [1:0]  priv_i;
  logic [3:0]  ebreak_en_i;
  logic        trap_o, mepc_we_o, sepc_we_o, dbg_enter_o;
  logic [31:0] trap_pc_o, mstatus_o, cause_o, saved_pc_o;
  logic [1:0]  priv_o, dbg_prv_o;

  int tests = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  trap_entry #(.XLEN(XLEN), .DBG_ENTRY(DENT), .DBG_TVEC(DTVC)) u_trap_entry (.*);

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_pend_i = '0; exc_valid_i = 0; exc_cause_i = '0; pc_i = 32'h1000;
    priv_i = 2'd0; mstatus_i = '0; medeleg_i = '0; mideleg_i = '0;
    mtvec_i = 32'h100; stvec_i = STV; dbg_mode_i = 0; ebreak_en_i = '0;
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset();
    chk("R1 trap", {31'd0, trap_o}, 0);
    chk("R1 priv", {30'd0, priv_o}, 3);
    chk("R1 we", {29'd0, mepc_we_o, sepc_we_o, dbg_enter_o}, 0);
  endtask

  task automatic t_m_irq();
    // R2 R4: priv S, two M-level pending, lowest wins
    @(negedge clk_i); idle(); priv_i = 1; mstatus_i = 32'h2; irq_pend_i = 32'h88; pc_i = 32'h1234;
    step();
    chk("R2 trap", {31'd0, trap_o}, 1);
    chk("R4 cause", cause_o, 32'h8000_0003);
    chk("R7 pc", trap_pc_o, 32'h100);
    chk("R8 mstatus", mstatus_o, 32'h0000_0802);
    chk("R8 we", {30'd0, mepc_we_o, sepc_we_o}, 2'b10);
    chk("R12 saved pc", saved_pc_o, 32'h1234);
  endtask

  task automatic t_vectored();
    @(negedge clk_i); idle(); priv_i = 3; mstatus_i = 32'h8; mtvec_i = 32'h101; irq_pend_i = 32'h80;
    step();
    chk("R7 vectored pc", trap_pc_o, 32'h11C);
    chk("R8 mstatus", mstatus_o, 32'h0000_1880);
  endtask

  task automatic t_m_masked();
    @(negedge clk_i); idle(); priv_i = 3; mstatus_i = 32'h0; irq_pend_i = 32'h80;
    step();
    chk("R2 masked at M", {31'd0, trap_o}, 0);
  endtask

  task automatic t_deleg_irq();
    @(negedge clk_i); idle(); mideleg_i = 32'h22; irq_pend_i = 32'h22;
    step();
    chk("R3 to S priv", {30'd0, priv_o}, 1);
    chk("R4 cause", cause_o, 32'h8000_0001);
    chk("R6 pc", trap_pc_o, STV);
    chk("R6 we", {30'd0, mepc_we_o, sepc_we_o}, 2'b01);
    // M-level beats lower delegated bit
    @(negedge clk_i); idle(); mideleg_i = 32'h2; irq_pend_i = 32'h82;
    step();
    chk("R3 M first", cause_o, 32'h8000_0007);
    chk("R3 M first priv", {30'd0, priv_o}, 3);
    // S with SIE clear
    @(negedge clk_i); idle(); priv_i = 1; mideleg_i = 32'h2; irq_pend_i = 32'h2;
    step();
    chk("R3 SIE clear", {31'd0, trap_o}, 0);
    @(negedge clk_i); idle(); priv_i = 1; mstatus_i = 32'h2; mideleg_i = 32'h2; irq_pend_i = 32'h2;
    step();
    chk("R6 mstatus", mstatus_o, 32'h0000_0120);
    // at M, delegated never taken
    @(negedge clk_i); idle(); priv_i = 3; mstatus_i = 32'hA; mideleg_i = 32'h2; irq_pend_i = 32'h2;
    step();
    chk("R3 at M", {31'd0, trap_o}, 0);
  endtask

  task automatic t_exc();
    @(negedge clk_i); idle(); mtvec_i = 32'h101; exc_valid_i = 1; exc_cause_i = 2; pc_i = 32'h4444;
    step();
    chk("R7 exc pc", trap_pc_o, 32'h100);
    chk("R5 exc cause", cause_o, 2);
    chk("R12 saved pc", saved_pc_o, 32'h4444);
    @(negedge clk_i); idle(); medeleg_i = 32'h100; exc_valid_i = 1; exc_cause_i = 8;
    step();
    chk("R5 deleg exc", {30'd0, priv_o}, 1);
    chk("R5 deleg pc", trap_pc_o, STV);
    @(negedge clk_i); idle(); priv_i = 3; medeleg_i = 32'h100; exc_valid_i = 1; exc_cause_i = 8;
    step();
    chk("R5 from M", {30'd0, priv_o}, 3);
    @(negedge clk_i); idle(); medeleg_i = '1; exc_valid_i = 1; exc_cause_i = 33;
    step();
    chk("R5 cause range", {30'd0, mepc_we_o, sepc_we_o}, 2'b10);
  endtask

  task automatic t_prio();
    @(negedge clk_i); idle(); irq_pend_i = 32'h800; exc_valid_i = 1; exc_cause_i = 5;
    step();
    chk("R9 irq wins", cause_o, 32'h8000_000B);
  endtask

  task automatic t_bkpt();
    @(negedge clk_i); idle(); priv_i = 1; mstatus_i = 32'h2; ebreak_en_i = 4'b0010;
    exc_valid_i = 1; exc_cause_i = 3; pc_i = 32'h5550;
    step();
    chk("R10 dbg", {31'd0, dbg_enter_o}, 1);
    chk("R10 pc", trap_pc_o, DENT);
    chk("R10 priv", {30'd0, priv_o}, 3);
    chk("R10 dprv", {30'd0, dbg_prv_o}, 1);
    chk("R10 dpc", saved_pc_o, 32'h5550);
    chk("R10 mstatus", mstatus_o, 32'h2);
    chk("R10 no we", {30'd0, mepc_we_o, sepc_we_o}, 0);
    @(negedge clk_i); idle(); priv_i = 1; ebreak_en_i = 4'b1101; exc_valid_i = 1; exc_cause_i = 3;
    step();
    chk("R10 disabled", {31'd0, dbg_enter_o}, 0);
    chk("R10 normal trap", cause_o, 3);
  endtask

  task automatic t_in_dbg();
    @(negedge clk_i); idle(); dbg_mode_i = 1; priv_i = 3; mstatus_i = 32'h8; ebreak_en_i = '1;
    exc_valid_i = 1; exc_cause_i = 3;
    step();
    chk("R11 bkpt pc", trap_pc_o, DENT);
    chk("R11 no dbg", {29'd0, dbg_enter_o, mepc_we_o, sepc_we_o}, 0);
    chk("R11 mstatus", mstatus_o, 32'h8);
    @(negedge clk_i); idle(); dbg_mode_i = 1; priv_i = 1; exc_valid_i = 1; exc_cause_i = 2;
    step();
    chk("R11 tvec", trap_pc_o, DTVC);
    chk("R11 priv kept", {30'd0, priv_o}, 1);
    @(negedge clk_i); idle(); dbg_mode_i = 1; irq_pend_i = 32'h80;
    step();
    chk("R11 irq ignored", {31'd0, trap_o}, 0);
  endtask

  initial begin
    idle();
    #23;
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_m_irq();
    t_vectored();
    t_m_masked();
    t_deleg_irq();
    t_exc();
    t_prio();
    t_bkpt();
    t_in_dbg();
    @(negedge clk_i); idle();
    step();
    chk("R12 idle", {31'd0, trap_o}, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule